// File: doc/BRIEF.md
# External interrupt sense controller

This block turns two asynchronous interrupt pins into interrupt requests for a processor. Each pin is brought into the clock domain through a synchroniser and then held in a sampling register. The block compares the synchronised value with the sampled one to find edges and changes. For each channel, a 2-bit mode field chooses one of four sense modes: low level, any change, falling edge or rising edge. A request reaches the output only when the channel's mask bit and the global interrupt enable input are both set.

In the edge and change modes, a detected event sets a sticky per-channel pending flag. Software clears the flag by writing a one to its bit in the flag register, or the interrupt logic clears it by pulsing the channel's acknowledge input. In low-level mode no flag is stored. The request follows the synchronised pin directly, so it goes away when the pin goes high again. Writing a different mode into a channel's field drops that channel's pending flag. The control, mask and flag registers are reached through a simple byte-wide register port. Reads are combinational and writes take effect on the clock edge.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control, mask and flag registers read zero, and no request is raised.
- R2: The mode register is at byte address 0x69. Bits 1:0 hold channel 0's mode and bits 3:2 hold channel 1's mode. Both fields read back as written. Mode codes: 00 low level, 01 any change, 10 falling edge, 11 rising edge.
- R3: Bits 7:4 of the mode register always read zero, and writing ones to them changes nothing.
- R4: In mode 00 the request follows the synchronised pin: it is asserted while the pin is low and withdrawn as soon as the pin is seen high. No pending flag is stored.
- R5: In mode 01 both a rise and a fall of the pin set the pending flag.
- R6: In mode 10 only a fall of the pin sets the pending flag.
- R7: In mode 11 only a rise of the pin sets the pending flag.
- R8: A pin change made between clock edges reaches the level request on the second rising edge and the pending flag on the third. A pulse held for two clock periods always sets the flag.
- R9: Channel c's request requires mask bit c and global enable to both be set. The mask register is at address 0x3D, with bit 0 for channel 0 and bit 1 for channel 1.
- R10: A one-cycle pulse on a channel's acknowledge input clears its pending flag.
- R11: The flag register is at address 0x3C, with bit c for channel c. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged.
- R12: A write that changes a channel's mode field clears that channel's pending flag. A write that leaves the field the same keeps the flag.
- R13: A pending flag stays set after the pin returns to its idle level, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational on regAddr |
| pinAsync | input | 2 | Asynchronous interrupt pins, one per channel |
| globalEn | input | 1 | Global interrupt enable |
| irqAck | input | 2 | Per-channel acknowledge, clears the pending flag |
| irqReq | output | 2 | Per-channel interrupt request |

## Verification
The hardest case to reach is the exact cycle in which a pin change first becomes visible. The level request moves after two edges, the flag after three, and before those points the outputs must still show the old state. The bench drives each pin on the falling clock edge. It then sweeps both channels, all four modes and both starting levels, and checks the request after one, two and three rising edges. After each transition it pulses the pin back, so that it can confirm which direction each edge mode captured. A second hard case is a mode write landing while a flag is pending. The bench sets a flag first, then rewrites the same mode and then a different mode, and reads the flag register after each write.

// File: rtl/eis_pkg.sv
package eis_pkg;

  localparam int CH_COUNT = 2;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic [CH_COUNT-1:0] modeChg;
    logic [CH_COUNT-1:0] flagWrClr;
  } ctlStrobes_t;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int WIDTH   = 2,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut
);

  logic [STAGES-1:0][WIDTH-1:0] chainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= {STAGES{{WIDTH{RST_VAL}}}};
    end else begin
      chainQ[0] <= dIn;
      for (int s = 1; s < STAGES; s++) begin
        chainQ[s] <= chainQ[s-1];
      end
    end
  end

  assign dOut = chainQ[STAGES-1];

endmodule

// File: rtl/eis_control.sv
module eis_control
  import eis_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 8,
  parameter int              NUM_CH    = CH_COUNT,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h69,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h3C
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          regAddr,
  input  logic                       regWrEn,
  input  logic [DATA_W-1:0]          regWrData,
  output logic [DATA_W-1:0]          regRdData,
  input  logic [NUM_CH-1:0]          flagBits,
  output logic [NUM_CH-1:0][MODE_W-1:0] modeSel,
  output logic [NUM_CH-1:0]          maskBits,
  output ctlStrobes_t                strobes
);

  localparam int FIELD_W = MODE_W * NUM_CH;

  logic [FIELD_W-1:0] ctrlQ;
  logic [NUM_CH-1:0]  maskQ;
  logic               wrCtrl;
  logic               wrMask;
  logic               wrFlag;
  logic               unusedWrBits;

  assign wrCtrl = regWrEn && (regAddr == CTRL_ADDR);
  assign wrMask = regWrEn && (regAddr == MASK_ADDR);
  assign wrFlag = regWrEn && (regAddr == FLAG_ADDR);

  // Reserved write bits are dropped
  assign unusedWrBits = ^regWrData[DATA_W-1:FIELD_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= '0;
      maskQ <= '0;
    end else begin
      if (wrCtrl) ctrlQ <= regWrData[FIELD_W-1:0];
      if (wrMask) maskQ <= regWrData[NUM_CH-1:0];
    end
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign modeSel[c] = ctrlQ[c*MODE_W +: MODE_W];
      assign strobes.modeChg[c] =
        wrCtrl && (regWrData[c*MODE_W +: MODE_W] != ctrlQ[c*MODE_W +: MODE_W]);
      assign strobes.flagWrClr[c] = wrFlag && regWrData[c];
    end
  endgenerate

  assign maskBits = maskQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == CTRL_ADDR) begin
      regRdData[FIELD_W-1:0] = ctrlQ;
    end else if (regAddr == MASK_ADDR) begin
      regRdData[NUM_CH-1:0] = maskQ;
    end else if (regAddr == FLAG_ADDR) begin
      regRdData[NUM_CH-1:0] = flagBits;
    end
  end

endmodule

// File: rtl/eis_datapath.sv
module eis_datapath
  import eis_pkg::*;
#(
  parameter int NUM_CH      = CH_COUNT,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH-1:0]             pinAsync,
  input  logic [NUM_CH-1:0][MODE_W-1:0] modeSel,
  input  logic [NUM_CH-1:0]             maskBits,
  input  logic                          globalEn,
  input  logic [NUM_CH-1:0]             irqAck,
  input  ctlStrobes_t                   strobes,
  output logic [NUM_CH-1:0]             irqReq,
  output logic [NUM_CH-1:0]             flagBits,
  output logic [NUM_CH-1:0]             syncPin,
  output logic [NUM_CH-1:0]             evtHit
);

  logic [NUM_CH-1:0] sampleQ;
  logic [NUM_CH-1:0] flagQ;
  logic [NUM_CH-1:0] flagNext;

  eis_sync #(
    .WIDTH  (NUM_CH),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) i_sync (
    .clk (clk),
    .rstN(rstN),
    .dIn (pinAsync),
    .dOut(syncPin)
  );

  // Sampling register: previous synchronised value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampleQ <= '1;
    else       sampleQ <= syncPin;
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      unique case (senseMode_e'(modeSel[c]))
        SENSE_ANY:  evtHit[c] = syncPin[c] ^ sampleQ[c];
        SENSE_FALL: evtHit[c] = ~syncPin[c] & sampleQ[c];
        SENSE_RISE: evtHit[c] = syncPin[c] & ~sampleQ[c];
        default:    evtHit[c] = 1'b0;
      endcase
    end
  end

  // Priority: mode change clear, then new event, then ack or software clear
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (strobes.modeChg[c])                           flagNext[c] = 1'b0;
      else if (evtHit[c])                               flagNext[c] = 1'b1;
      else if (irqAck[c] || strobes.flagWrClr[c])       flagNext[c] = 1'b0;
      else                                              flagNext[c] = flagQ[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= flagNext;
  end

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_req
      logic srcActive;
      assign srcActive = (senseMode_e'(modeSel[c]) == SENSE_LOW) ? ~syncPin[c] : flagQ[c];
      assign irqReq[c] = globalEn & maskBits[c] & srcActive;
    end
  endgenerate

  assign flagBits = flagQ;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 8,
  parameter int   NUM_CH      = CH_COUNT,
  parameter int   SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h69,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 8'h3D,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NUM_CH-1:0] pinAsync,
  input  logic              globalEn,
  input  logic [NUM_CH-1:0] irqAck,
  output logic [NUM_CH-1:0] irqReq
);

  logic [NUM_CH-1:0][MODE_W-1:0] modeSel;
  logic [NUM_CH-1:0]             maskBits;
  logic [NUM_CH-1:0]             flagBits;
  logic [NUM_CH-1:0]             syncPin;
  logic [NUM_CH-1:0]             evtHit;
  ctlStrobes_t                   strobes;

  eis_control #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_CH   (NUM_CH),
    .CTRL_ADDR(CTRL_ADDR),
    .MASK_ADDR(MASK_ADDR),
    .FLAG_ADDR(FLAG_ADDR)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .flagBits (flagBits),
    .modeSel  (modeSel),
    .maskBits (maskBits),
    .strobes  (strobes)
  );

  eis_datapath #(
    .NUM_CH     (NUM_CH),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .pinAsync(pinAsync),
    .modeSel (modeSel),
    .maskBits(maskBits),
    .globalEn(globalEn),
    .irqAck  (irqAck),
    .strobes (strobes),
    .irqReq  (irqReq),
    .flagBits(flagBits),
    .syncPin (syncPin),
    .evtHit  (evtHit)
  );

endmodule

// File: rtl/ext_irq_sense_checker.sv
module ext_irq_sense_checker
  import eis_pkg::*;
#(
  parameter int   ADDR_W    = 8,
  parameter int   DATA_W    = 8,
  parameter int   NUM_CH    = CH_COUNT,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h69
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             regAddr,
  input logic [DATA_W-1:0]             regRdData,
  input logic                          globalEn,
  input logic [NUM_CH-1:0]             irqAck,
  input logic [NUM_CH-1:0]             irqReq,
  input logic [NUM_CH-1:0][MODE_W-1:0] modeSel,
  input logic [NUM_CH-1:0]             maskBits,
  input logic [NUM_CH-1:0]             flagBits,
  input logic [NUM_CH-1:0]             syncPin,
  input logic [NUM_CH-1:0]             evtHit,
  input logic [NUM_CH-1:0]             modeChg
);

  localparam int FIELD_W = MODE_W * NUM_CH;

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == CTRL_ADDR) |-> (regRdData[DATA_W-1:FIELD_W] == '0));

  assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> (irqReq == '0));

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
        !maskBits[c] |-> !irqReq[c]);

      assert_level_withdraw_R4: assert property (@(posedge clk) disable iff (!rstN)
        (modeSel[c] == 2'b00) && syncPin[c] |-> !irqReq[c]);

      assert_fall_only_R6: assert property (@(posedge clk) disable iff (!rstN)
        (modeSel[c] == 2'b10) && evtHit[c] |-> !syncPin[c]);

      assert_rise_only_R7: assert property (@(posedge clk) disable iff (!rstN)
        (modeSel[c] == 2'b11) && evtHit[c] |-> syncPin[c]);

      assert_event_sticks_R13: assert property (@(posedge clk) disable iff (!rstN)
        evtHit[c] && !modeChg[c] |=> flagBits[c]);

      assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
        irqAck[c] && !evtHit[c] && !modeChg[c] |=> !flagBits[c]);

      assert_mode_change_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
        modeChg[c] |=> !flagBits[c]);
    end
  endgenerate

endmodule

bind ext_irq_sense ext_irq_sense_checker #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .NUM_CH   (NUM_CH),
  .CTRL_ADDR(CTRL_ADDR)
) i_checker (
  .clk      (clk),
  .rstN     (rstN),
  .regAddr  (regAddr),
  .regRdData(regRdData),
  .globalEn (globalEn),
  .irqAck   (irqAck),
  .irqReq   (irqReq),
  .modeSel  (modeSel),
  .maskBits (maskBits),
  .flagBits (flagBits),
  .syncPin  (syncPin),
  .evtHit   (evtHit),
  .modeChg  (strobes.modeChg)
);

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CTRL_A = 8'h69;
  localparam logic [7:0] MASK_A = 8'h3D;
  localparam logic [7:0] FLAG_A = 8'h3C;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] pinAsync = 2'b11;
  logic       globalEn = 1'b1;
  logic [1:0] irqAck = 2'b00;
  logic [1:0] irqReq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  ext_irq_sense i_ext_irq_sense (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .pinAsync (pinAsync),
    .globalEn (globalEn),
    .irqAck   (irqAck),
    .irqReq   (irqReq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] addr, output logic [7:0] data);
    regAddr = addr;
    #1;
    data = regRdData;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic expEvt(input int mode, input logic from, input logic to);
    case (mode)
      1: return from != to;
      2: return from & ~to;
      3: return ~from & to;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic lvl(input int mode, input logic v);
    return (mode == 0) && !v;
  endfunction

  function automatic string modeTag(input int mode);
    case (mode)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Raise a pending flag on channel ch with a two-cycle low pulse
  task automatic pulseLow(input int ch);
    @(negedge clk); pinAsync[ch] = 1'b0;
    waitCycles(2);
    pinAsync[ch] = 1'b1;
    waitCycles(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=timeout expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [1:0] e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitCycles(3);

    // R1: reset state
    rdReg(CTRL_A, rd); chk("R1 ctrl", rd, 8'h00);
    rdReg(MASK_A, rd); chk("R1 mask", rd, 8'h00);
    rdReg(FLAG_A, rd); chk("R1 flag", rd, 8'h00);
    chk("R1 req", {6'b0, irqReq}, 8'h00);

    // R2 / R3: field readback and reserved bits
    wrReg(CTRL_A, 8'h0E); rdReg(CTRL_A, rd); chk("R2 readback", rd, 8'h0E);
    wrReg(CTRL_A, 8'hF5); rdReg(CTRL_A, rd); chk("R3 reserved", rd, 8'h05);
    wrReg(CTRL_A, 8'h00);

    // R9: mask register position
    wrReg(MASK_A, 8'hFF); rdReg(MASK_A, rd); chk("R9 mask readback", rd, 8'h03);

    // Sweep channel x mode x starting level
    for (int ch = 0; ch < 2; ch++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int s = 0; s < 2; s++) begin
          logic st;
          st = s[0];
          pinAsync[ch] = st;
          waitCycles(5);
          wrReg(CTRL_A, 8'(mode << (2*ch)));
          wrReg(FLAG_A, 8'h03);
          chk({modeTag(mode), " idle"}, {6'b0, irqReq}, 8'({1'b0, lvl(mode, st)} << ch));
          pinAsync[ch] = ~st;
          @(negedge clk);
          chk("R8 one edge", {6'b0, irqReq}, 8'({1'b0, lvl(mode, st)} << ch));
          @(negedge clk);
          chk("R8 two edges", {6'b0, irqReq}, 8'({1'b0, lvl(mode, ~st)} << ch));
          @(negedge clk);
          e = (mode == 0) ? {1'b0, lvl(mode, ~st)} : {1'b0, expEvt(mode, st, ~st)};
          chk({modeTag(mode), " after change"}, {6'b0, irqReq}, 8'(e << ch));
          pinAsync[ch] = st;
          waitCycles(4);
          e = (mode == 0) ? {1'b0, lvl(mode, st)}
                          : {1'b0, expEvt(mode, st, ~st) | expEvt(mode, ~st, st)};
          chk({modeTag(mode), " after pulse back"}, {6'b0, irqReq}, 8'(e << ch));
          irqAck[ch] = 1'b1;
          @(negedge clk);
          irqAck[ch] = 1'b0;
          chk("R10 ack", {6'b0, irqReq}, 8'({1'b0, lvl(mode, st)} << ch));
        end
      end
      pinAsync[ch] = 1'b1;
      waitCycles(4);
    end

    // R9 / R13: gating and stickiness, rising mode on channel 0
    wrReg(CTRL_A, 8'h03);
    wrReg(FLAG_A, 8'h03);
    pulseLow(0);
    chk("R13 sticky", {6'b0, irqReq}, 8'h01);
    rdReg(FLAG_A, rd); chk("R13 flag read", rd, 8'h01);
    wrReg(MASK_A, 8'h02); chk("R9 mask off", {6'b0, irqReq}, 8'h00);
    wrReg(MASK_A, 8'h03); globalEn = 1'b0; #1;
    chk("R9 global off", {6'b0, irqReq}, 8'h00);
    @(negedge clk); globalEn = 1'b1; #1;
    chk("R9 both on", {6'b0, irqReq}, 8'h01);

    // R11: write-one-to-clear
    wrReg(FLAG_A, 8'h02); rdReg(FLAG_A, rd); chk("R11 zero keeps", rd, 8'h01);
    wrReg(FLAG_A, 8'h01); rdReg(FLAG_A, rd); chk("R11 one clears", rd, 8'h00);

    // R12: same mode keeps flag, different mode clears it
    pulseLow(0);
    rdReg(FLAG_A, rd); chk("R12 flag set", rd, 8'h01);
    wrReg(CTRL_A, 8'h03); rdReg(FLAG_A, rd); chk("R12 same mode", rd, 8'h01);
    wrReg(CTRL_A, 8'h02); rdReg(FLAG_A, rd); chk("R12 mode change", rd, 8'h00);

    // R8: two-cycle pulse in falling mode on channel 1
    wrReg(CTRL_A, 8'h08);
    wrReg(FLAG_A, 8'h03);
    pulseLow(1);
    chk("R8 short pulse", {6'b0, irqReq}, 8'h02);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule